// File: doc/BRIEF.md
# Early Jump Redirect at Decode

This block sits in the decode stage of a small in-order five-stage pipeline. It finds unconditional jumps whose target is the PC plus an immediate, in full-width and compressed form. For each one it sends fetch to the new address straight from decode. Without it, every change of flow waits until writeback and costs five cycles. A build-time policy can also steer conditional branches early: never, always, or only when the branch offset is negative.

The block takes the decoded instruction word, its PC, a compressed flag, a valid bit and a decode stall. When an instruction is accepted (valid and not stalled), the result is registered. In the next cycle the block raises a one-cycle redirect strobe with the target address. In that same cycle it raises a flush that drops the younger instruction sitting in decode behind the jump.

Toward execute, the block passes a valid bit and a link value: PC+4 for a full-width instruction, PC+2 for a compressed one. It also passes a tag that tells writeback the change of flow has already been made, so writeback does not redirect a second time. Jumps through a register are left entirely to writeback.

Top module: `early_jump_redirect`

## Requirements
- R1: An accepted full-width jump (opcode bits [6:0] = 1101111) produces, one cycle after acceptance, `redirect_o` = 1 for exactly one cycle, with `redirect_pc_o` = PC + sign-extended J-format offset.
- R2: An accepted compressed c.j or c.jal (bits [1:0] = 01, bits [15:13] = 101 or 001) produces the same one-cycle redirect, with the target PC + sign-extended CJ-format offset.
- R3: For every accepted instruction, `ex_link_o` in the following cycle equals PC+4 when the instruction is full width and PC+2 when it is compressed.
- R4: Register jumps never redirect and are never tagged. These are jalr (opcode 1100111), c.jr (bits [15:12] = 1000, rs1 != 0, rs2 = 0, bits [1:0] = 10) and c.jalr (bits [15:12] = 1001, same fields).
- R5: While `dec_stall_i` is high, no redirect is produced for the held instruction. When the stall drops, the instruction is accepted and exactly one redirect pulse follows.
- R6: `flush_o` is high in the same cycle as `redirect_o`. The instruction presented in decode during that cycle is dropped: `ex_valid_o` is 0 in the next cycle and that instruction raises no redirect.
- R7: `ex_early_o` is 1, together with `ex_valid_o`, for exactly the accepted instructions that caused a redirect, and 0 for all others.
- R8: With the no-prediction policy, conditional branches never redirect. These are B-format (opcode 1100011), c.beqz and c.bnez (bits [1:0] = 01, bits [15:13] = 110 or 111).
- R9: With the always-taken policy, every accepted conditional branch redirects to PC + its sign-extended offset and is tagged.
- R10: With the backward policy, a conditional branch redirects only when its offset is negative. A forward branch is not redirected and not tagged.
- R11: During reset, and for cycles with no accepted instruction, `redirect_o`, `flush_o`, `ex_valid_o`, `ex_early_o` and `ex_link_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decode slot holds an instruction |
| dec_instr_i | input | 32 | Instruction word; a compressed instruction is in bits [15:0] |
| dec_pc_i | input | XLEN | PC of the decode instruction |
| dec_cmp_i | input | 1 | Instruction is 16-bit compressed |
| dec_stall_i | input | 1 | Decode held by a later stage |
| redirect_o | output | 1 | One-cycle request to fetch from a new address |
| redirect_pc_o | output | XLEN | Target address, valid while redirect_o is high |
| flush_o | output | 1 | Discard the younger instruction behind the jump |
| ex_valid_o | output | 1 | Instruction handed to execute |
| ex_early_o | output | 1 | Change of flow already made in decode |
| ex_link_o | output | XLEN | Return address for the handed-on instruction |

## Verification
Two things can fall on the same cycle: the redirect and flush of an accepted jump, and the arrival in decode of the next fetched instruction, which may itself be eligible. The bench provokes this by presenting jumps and predicted branches back to back, and by releasing a stall directly in front of a following jump. The scoreboard models each policy's flush state on its own, so the younger jump must vanish: no valid, no tag, no second pulse. The instruction after the flush cycle must then be accepted normally.

// File: rtl/ejr_pkg.sv
package ejr_pkg;
  typedef enum logic [1:0] {
    BR_NONE     = 2'd0,
    BR_ALWAYS   = 2'd1,
    BR_BACKWARD = 2'd2
  } br_policy_e;

  localparam int unsigned OFF_W = 21;  // widest immediate offset (J format)
endpackage

// File: rtl/ejr_classify.sv
module ejr_classify
  import ejr_pkg::*;
(
  input  logic [31:0]      instr_i,
  input  logic             cmp_i,
  output logic             is_jump_o,
  output logic             is_branch_o,
  output logic             is_indirect_o,
  output logic [OFF_W-1:0] off_o
);
  logic [6:0] op;
  logic [1:0] quad;
  logic [2:0] cf3;
  logic [OFF_W-1:0] off_j, off_b, off_cj, off_cb;

  assign op   = instr_i[6:0];
  assign quad = instr_i[1:0];
  assign cf3  = instr_i[15:13];

  assign off_j  = {instr_i[31], instr_i[19:12], instr_i[20], instr_i[30:21], 1'b0};
  assign off_b  = {{8{instr_i[31]}}, instr_i[31], instr_i[7], instr_i[30:25],
                   instr_i[11:8], 1'b0};
  assign off_cj = {{9{instr_i[12]}}, instr_i[12], instr_i[8], instr_i[10:9], instr_i[6],
                   instr_i[7], instr_i[2], instr_i[11], instr_i[5:3], 1'b0};
  assign off_cb = {{12{instr_i[12]}}, instr_i[12], instr_i[6:5], instr_i[2],
                   instr_i[11:10], instr_i[4:3], 1'b0};

  always_comb begin
    is_jump_o     = 1'b0;
    is_branch_o   = 1'b0;
    is_indirect_o = 1'b0;
    off_o         = '0;
    if (cmp_i) begin
      if (quad == 2'b01 && (cf3 == 3'b101 || cf3 == 3'b001)) begin
        is_jump_o = 1'b1;
        off_o     = off_cj;
      end else if (quad == 2'b01 && cf3[2:1] == 2'b11) begin
        is_branch_o = 1'b1;
        off_o       = off_cb;
      end else if (quad == 2'b10 && cf3 == 3'b100 &&
                   instr_i[11:7] != 5'd0 && instr_i[6:2] == 5'd0) begin
        is_indirect_o = 1'b1;
      end
    end else begin
      unique case (op)
        7'b1101111: begin is_jump_o = 1'b1; off_o = off_j; end
        7'b1100011: begin is_branch_o = 1'b1; off_o = off_b; end
        7'b1100111: is_indirect_o = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/ejr_policy.sv
module ejr_policy
  import ejr_pkg::*;
#(
  parameter br_policy_e POLICY = BR_BACKWARD
) (
  input  logic is_jump_i,
  input  logic is_branch_i,
  input  logic back_i,
  output logic take_o
);
  logic br_take;

  generate
    if (POLICY == BR_ALWAYS) begin : g_always
      assign br_take = is_branch_i;
    end else if (POLICY == BR_BACKWARD) begin : g_back
      assign br_take = is_branch_i & back_i;
    end else begin : g_none
      assign br_take = 1'b0;
    end
  endgenerate

  assign take_o = is_jump_i | br_take;
endmodule

// File: rtl/ejr_ctl.sv
module ejr_ctl #(
  parameter int unsigned XLEN = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            stall_i,
  input  logic            take_i,
  input  logic [XLEN-1:0] target_i,
  input  logic [XLEN-1:0] link_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            flush_o,
  output logic            ex_valid_o,
  output logic            ex_early_o,
  output logic [XLEN-1:0] ex_link_o
);
  logic            redirect_q, ex_valid_q, ex_early_q;
  logic [XLEN-1:0] target_q, link_q;
  logic            accept;

  // a redirect in flight kills the younger instruction now in decode
  assign accept = valid_i & ~stall_i & ~redirect_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_q <= 1'b0;
      ex_valid_q <= 1'b0;
      ex_early_q <= 1'b0;
      target_q   <= '0;
      link_q     <= '0;
    end else begin
      redirect_q <= accept & take_i;
      ex_valid_q <= accept;
      ex_early_q <= accept & take_i;
      link_q     <= accept ? link_i : '0;
      if (accept & take_i) target_q <= target_i;
    end
  end

  assign redirect_o    = redirect_q;
  assign redirect_pc_o = target_q;
  assign flush_o       = redirect_q;
  assign ex_valid_o    = ex_valid_q;
  assign ex_early_o    = ex_early_q;
  assign ex_link_o     = link_q;

  assert_flush_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !ex_valid_o && !redirect_o);
  assert_single_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |=> !redirect_o);
  assert_stall_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> !redirect_o);
  assert_tag_match_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> ex_early_o && ex_valid_o);
  assert_idle_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !ex_valid_o && !ex_early_o && ex_link_o == '0);
endmodule

// File: rtl/early_jump_redirect.sv
module early_jump_redirect
  import ejr_pkg::*;
#(
  parameter int unsigned XLEN   = 32,
  parameter br_policy_e  POLICY = BR_BACKWARD
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            dec_valid_i,
  input  logic [31:0]     dec_instr_i,
  input  logic [XLEN-1:0] dec_pc_i,
  input  logic            dec_cmp_i,
  input  logic            dec_stall_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] redirect_pc_o,
  output logic            flush_o,
  output logic            ex_valid_o,
  output logic            ex_early_o,
  output logic [XLEN-1:0] ex_link_o
);
  localparam int unsigned EXT_W = XLEN - OFF_W;

  logic             is_jump, is_branch, is_indirect, take;
  logic [OFF_W-1:0] off;
  logic [XLEN-1:0]  off_ext, target, link;

  ejr_classify u_classify (
    .instr_i      (dec_instr_i),
    .cmp_i        (dec_cmp_i),
    .is_jump_o    (is_jump),
    .is_branch_o  (is_branch),
    .is_indirect_o(is_indirect),
    .off_o        (off)
  );

  ejr_policy #(.POLICY(POLICY)) u_policy (
    .is_jump_i  (is_jump),
    .is_branch_i(is_branch),
    .back_i     (off[OFF_W-1]),
    .take_o     (take)
  );

  assign off_ext = {{EXT_W{off[OFF_W-1]}}, off};
  assign target  = dec_pc_i + off_ext;
  assign link    = dec_pc_i + (dec_cmp_i ? XLEN'(2) : XLEN'(4));

  ejr_ctl #(.XLEN(XLEN)) u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (dec_valid_i),
    .stall_i      (dec_stall_i),
    .take_i       (take),
    .target_i     (target),
    .link_i       (link),
    .redirect_o   (redirect_o),
    .redirect_pc_o(redirect_pc_o),
    .flush_o      (flush_o),
    .ex_valid_o   (ex_valid_o),
    .ex_early_o   (ex_early_o),
    .ex_link_o    (ex_link_o)
  );

  assert_no_indirect_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_valid_i && is_indirect |=> !redirect_o && !ex_early_o);

  generate
    if (POLICY == BR_NONE) begin : g_chk_none
      assert_no_branch_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_valid_i && is_branch |=> !redirect_o);
    end else if (POLICY == BR_BACKWARD) begin : g_chk_back
      assert_fwd_branch_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_valid_i && is_branch && !dec_instr_i[dec_cmp_i ? 12 : 31] |=> !redirect_o);
    end
  endgenerate
endmodule

// File: tb/early_jump_redirect_test.sv
module early_jump_redirect_test;
  import ejr_pkg::*;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic v = 1'b0, st = 1'b0, cmp = 1'b0;
  logic [31:0] ins = 32'h0, pc = 32'h0;

  logic rd_b, fl_b, exv_b, exe_b, rd_n, fl_n, exv_n, exe_n, rd_a, fl_a, exv_a, exe_a;
  logic [31:0] tg_b, lk_b, tg_n, lk_n, tg_a, lk_a;

  early_jump_redirect #(.XLEN(32), .POLICY(BR_BACKWARD)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .dec_valid_i(v), .dec_instr_i(ins), .dec_pc_i(pc),
    .dec_cmp_i(cmp), .dec_stall_i(st), .redirect_o(rd_b), .redirect_pc_o(tg_b),
    .flush_o(fl_b), .ex_valid_o(exv_b), .ex_early_o(exe_b), .ex_link_o(lk_b));
  early_jump_redirect #(.XLEN(32), .POLICY(BR_NONE)) uut_none (
    .clk_i(clk), .rst_ni(rst_ni), .dec_valid_i(v), .dec_instr_i(ins), .dec_pc_i(pc),
    .dec_cmp_i(cmp), .dec_stall_i(st), .redirect_o(rd_n), .redirect_pc_o(tg_n),
    .flush_o(fl_n), .ex_valid_o(exv_n), .ex_early_o(exe_n), .ex_link_o(lk_n));
  early_jump_redirect #(.XLEN(32), .POLICY(BR_ALWAYS)) uut_always (
    .clk_i(clk), .rst_ni(rst_ni), .dec_valid_i(v), .dec_instr_i(ins), .dec_pc_i(pc),
    .dec_cmp_i(cmp), .dec_stall_i(st), .redirect_o(rd_a), .redirect_pc_o(tg_a),
    .flush_o(fl_a), .ex_valid_o(exv_a), .ex_early_o(exe_a), .ex_link_o(lk_a));

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct {
    logic        valid, redirect, early, rd_none, rd_always;
    logic [31:0] target, link;
    string       rq;
  } item_t;
  item_t sb[$];

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic m_fb = 1'b0, m_fn = 1'b0, m_fa = 1'b0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  // encoders written from the instruction formats
  function automatic logic [31:0] e_jal(input logic [31:0] o);
    return {o[20], o[10:1], o[11], o[19:12], 5'd1, 7'b1101111};
  endfunction
  function automatic logic [31:0] e_br(input logic [31:0] o);
    return {o[12], o[10:5], 5'd2, 5'd3, 3'b000, o[4:1], o[11], 7'b1100011};
  endfunction
  function automatic logic [31:0] e_cj(input logic [2:0] f3, input logic [31:0] o);
    return {16'h0, f3, o[11], o[4], o[9:8], o[10], o[6], o[7], o[3:1], o[5], 2'b01};
  endfunction
  function automatic logic [31:0] e_cb(input logic [2:0] f3, input logic [31:0] o);
    return {16'h0, f3, o[8], o[4:3], 3'd1, o[7:6], o[2:1], o[5], 2'b01};
  endfunction

  // kind: 0 other, 1 immediate jump, 2 conditional branch
  task automatic step(input logic iv, input logic ist, input logic icmp,
                      input logic [31:0] iins, input logic [31:0] ipc,
                      input int kind, input logic [31:0] off, input string rq);
    item_t it;
    logic ab, an, aa;
    @(negedge clk);
    v = iv; st = ist; cmp = icmp; ins = iins; pc = ipc;
    ab = iv & ~ist & ~m_fb;
    an = iv & ~ist & ~m_fn;
    aa = iv & ~ist & ~m_fa;
    it.valid     = ab;
    it.redirect  = ab & (kind == 1 || (kind == 2 && off[31]));
    it.early     = it.redirect;
    it.rd_none   = an & (kind == 1);
    it.rd_always = aa & (kind != 0);
    it.target    = ipc + off;
    it.link      = ab ? ipc + (icmp ? 32'd2 : 32'd4) : 32'd0;
    it.rq        = rq;
    m_fb = it.redirect; m_fn = it.rd_none; m_fa = it.rd_always;
    sb.push_back(it);
  endtask

  task automatic idle();
    step(1'b0, 1'b0, 1'b0, 32'h0, 32'h0, 0, 32'h0, "R11");
  endtask

  initial begin : monitor
    item_t e;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() != 0) begin
        e = sb.pop_front();
        chk(rd_b == e.redirect, e.rq, "redirect", {31'h0, rd_b}, {31'h0, e.redirect});
        chk(fl_b == e.redirect, "R6", "flush", {31'h0, fl_b}, {31'h0, e.redirect});
        chk(exv_b == e.valid, e.rq, "ex_valid", {31'h0, exv_b}, {31'h0, e.valid});
        chk(exe_b == e.early, "R7", "early tag", {31'h0, exe_b}, {31'h0, e.early});
        chk(lk_b == e.link, "R3", "link", lk_b, e.link);
        if (e.redirect) chk(tg_b == e.target, e.rq, "target", tg_b, e.target);
        chk(rd_n == e.rd_none, "R8", "none-policy redirect", {31'h0, rd_n}, {31'h0, e.rd_none});
        chk(rd_a == e.rd_always, "R9", "always-policy redirect", {31'h0, rd_a},
            {31'h0, e.rd_always});
        if (e.rd_always) chk(tg_a == e.target, "R9", "always target", tg_a, e.target);
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    chk(!rd_b && !fl_b && !exv_b && !exe_b && lk_b == 0, "R11", "reset outputs",
        {27'h0, rd_b, fl_b, exv_b, exe_b, |lk_b}, 32'h0);
    rst_ni = 1'b1;
    idle();
    step(1, 0, 0, 32'h00000013, 32'h0000_0100, 0, 0, "R11");             // plain op
    step(1, 0, 0, e_jal(32'h100), 32'h0000_1000, 1, 32'h100, "R1");       // jal fwd
    step(1, 0, 0, e_jal(32'h40), 32'h0000_1004, 1, 32'h40, "R6");         // younger, flushed
    step(1, 0, 0, e_jal(-32'sd2048), 32'h0000_2000, 1, -32'sd2048, "R1"); // jal back
    idle();
    step(1, 0, 1, e_cj(3'b101, 32'h24), 32'h0000_3000, 1, 32'h24, "R2");  // c.j
    idle();
    step(1, 0, 1, e_cj(3'b001, -32'sd16), 32'h0000_3100, 1, -32'sd16, "R2"); // c.jal
    idle();
    step(1, 0, 0, 32'h00008067, 32'h0000_4000, 0, 0, "R4");               // jalr
    step(1, 0, 1, 32'h00008082, 32'h0000_4004, 0, 0, "R4");               // c.jr
    step(1, 0, 1, 32'h00009082, 32'h0000_4006, 0, 0, "R4");               // c.jalr
    for (int i = 0; i < 3; i++)
      step(1, 1, 0, e_jal(32'h80), 32'h0000_5000, 1, 32'h80, "R5");       // held
    step(1, 0, 0, e_jal(32'h80), 32'h0000_5000, 1, 32'h80, "R5");         // released
    step(1, 0, 0, e_jal(32'h10), 32'h0000_5004, 1, 32'h10, "R5");         // behind it
    idle();
    step(1, 0, 0, e_br(32'h40), 32'h0000_6000, 2, 32'h40, "R10");         // fwd beq
    idle();
    step(1, 0, 0, e_br(-32'sd64), 32'h0000_6100, 2, -32'sd64, "R10");     // back beq
    step(1, 0, 0, e_br(-32'sd32), 32'h0000_6104, 2, -32'sd32, "R9");      // after flush
    idle();
    step(1, 0, 1, e_cb(3'b110, -32'sd16), 32'h0000_7000, 2, -32'sd16, "R10"); // c.beqz back
    idle();
    step(1, 0, 1, e_cb(3'b111, 32'h20), 32'h0000_7010, 2, 32'h20, "R10"); // c.bnez fwd
    step(0, 0, 0, e_jal(32'h8), 32'h0000_8000, 1, 32'h8, "R11");          // not valid
    idle();
    idle();
    @(posedge clk); #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule